// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Prescaler

The block keeps a wall-clock time and a calendar date in packed BCD and steps them forward once per second. The second pulse is made by two cascaded down-counters on the RTC clock: a short asynchronous stage feeds a long synchronous stage, and the pulse period is the product of the two divide ratios. The calendar understands month lengths, leap Februaries (any year divisible by four), the December-to-January wrap with a year carry, a year wrap from 99 to 00 and a weekday that counts 1 (Monday) to 7 (Sunday).

Software reaches the block through a small word-wide register port. To load a new time, date or divider setting it raises an init request, waits until the acknowledge flag shows that counting has stopped, writes the words and drops the request, after which counting resumes from the loaded values. Reads return shadow copies of the counters. A resync flag says whether those shadows match the live counters: software clears it, and the hardware sets it again once the shadows have been refreshed.

Register map (word address on `addr`): 0 = time word (seconds BCD in bits 6:0, minutes in 14:8, hours 00..23 in 21:16); 1 = date word (day of month in 5:0, month in 12:8, weekday in 15:13, year in 23:16); 2 = status/control (bit 0 init request, read/write; bit 1 init acknowledge, read-only; bit 2 resync flag, writing 0 clears it, writing 1 leaves it; bit 3 calendar-initialized flag, read-only); 3 = divider word (synchronous divider in 14:0, asynchronous divider in 22:16).

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00002101 (day 01, month 01, weekday 1, year 00), the status word reads 0x4 and the divider word reads 0x007F00FF.
- R2: The init acknowledge (status bit 1) rises two clock cycles after a write sets the init request (status bit 0) and falls two cycles after a write clears it; the first read issued after such a write and the one after it still show the old value, the third shows the new one.
- R3: Writes to the time, date and divider words are ignored while the init acknowledge is 0.
- R4: With asynchronous divider A and synchronous divider S the one-second pulse `tick` recurs every (A+1)*(S+1) clock cycles, and no pulse occurs while the init acknowledge is 1.
- R5: Seconds and minutes roll over from 59 to 00 with a carry, decimal digits carry in BCD (09 -> 10), and hours roll over from 23 to 00 with a day carry.
- R6: The day of month rolls over to 01 after day 30 in April, June, September and November and after day 31 in the other months except February; month 12 rolls to 01 and increments the year.
- R7: February ends at day 29 when the BCD year is divisible by four and at day 28 otherwise.
- R8: The weekday advances by one on every day carry, and from 7 to 1.
- R9: Writing 0 to status bit 2 clears the resync flag, which reads 0 for the next two reads and 1 on the third; writing 1 to it has no effect.
- R10: Status bit 3 reads 1 exactly when the calendar year is nonzero.
- R11: The calendar does not advance while the init acknowledge is 1, and after init mode is left it counts on from the values loaded.
- R12: Year 99 wraps to year 00 on the year carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid one cycle later |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick | output | 1 | One-cycle pulse at each calendar second |

## Verification
The bench keeps the default divider widths and reset ratios, so the reset divider word is checked as 127/255, then loads an asynchronous ratio of 1 and a synchronous ratio of 2 during init mode, giving a six-cycle second. That short second puts every rollover within a few cycles of a load: the bench starts each case one second before a minute, day, month or year boundary, including leap and non-leap Februaries and a weekday wrap. The long reset ratio keeps the first scenarios free of any pulse, so the resync flag and the write-ignore behaviour are seen without interference from counting.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // BCD increment of a two-digit value; 99 wraps to 00
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v == 8'h99)       return 8'h00;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                  return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // last day of a month, BCD
  function automatic logic [7:0] bcd_month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int A_W   = 7,
  parameter int S_W   = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic [A_W-1:0] a_div,
  input  logic [S_W-1:0] s_div,
  output logic           tick
);
  logic [A_W-1:0] a_cnt;
  logic [S_W-1:0] s_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= a_div;
      s_cnt <= s_div;
      tick  <= 1'b0;
    end else if (hold) begin
      a_cnt <= a_div;
      s_cnt <= s_div;
      tick  <= 1'b0;
    end else if (a_cnt == '0) begin
      a_cnt <= a_div;
      if (s_cnt == '0) begin
        s_cnt <= s_div;
        tick  <= 1'b1;
      end else begin
        s_cnt <= s_cnt - 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      a_cnt <= a_cnt - 1'b1;
      tick  <= 1'b0;
    end
  end

  AST_NO_TICK_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tick); // R4

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hold,
  input  logic        step,
  input  logic        load_time,
  input  logic        load_date,
  input  logic [31:0] wr_word,
  output logic [31:0] time_word,
  output logic [31:0] date_word
);
  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic [2:0] wd_q;
  logic [7:0] sec_n, min_n, hr_n, day_n, mon_n, yr_n;
  logic [2:0] wd_n;
  logic       unused_bits;

  assign unused_bits = ^{wr_word[31:24], wr_word[7]};

  always_comb begin
    sec_n = bcd_inc(sec_q);
    min_n = min_q;
    hr_n  = hr_q;
    day_n = day_q;
    mon_n = mon_q;
    yr_n  = yr_q;
    wd_n  = wd_q;
    if (sec_q == 8'h59) begin
      sec_n = 8'h00;
      min_n = bcd_inc(min_q);
      if (min_q == 8'h59) begin
        min_n = 8'h00;
        hr_n  = bcd_inc(hr_q);
        if (hr_q == 8'h23) begin
          hr_n  = 8'h00;
          day_n = bcd_inc(day_q);
          wd_n  = (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
          if (day_q == bcd_month_end(mon_q, yr_q)) begin
            day_n = 8'h01;
            mon_n = bcd_inc(mon_q);
            if (mon_q == 8'h12) begin
              mon_n = 8'h01;
              yr_n  = bcd_inc(yr_q);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00; wd_q <= 3'd1;
    end else if (hold) begin
      if (load_time) begin
        sec_q <= {1'b0, wr_word[6:0]};
        min_q <= {1'b0, wr_word[14:8]};
        hr_q  <= {2'b0, wr_word[21:16]};
      end
      if (load_date) begin
        day_q <= {2'b0, wr_word[5:0]};
        mon_q <= {3'b0, wr_word[12:8]};
        wd_q  <= wr_word[15:13];
        yr_q  <= wr_word[23:16];
      end
    end else if (step) begin
      sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n;
      day_q <= day_n; mon_q <= mon_n; yr_q <= yr_n; wd_q <= wd_n;
    end
  end

  assign time_word = {10'b0, hr_q[5:0], 1'b0, min_q[6:0], 1'b0, sec_q[6:0]};
  assign date_word = {8'b0, yr_q, wd_q, mon_q[4:0], 2'b0, day_q[5:0]};

  AST_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    (hold && !load_time) |=> $stable(time_word)); // R11

  AST_DATE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load_date) |=> $stable(date_word)); // R11

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int A_W     = 7,
  parameter int S_W     = 15,
  parameter int A_RESET = 127,
  parameter int S_RESET = 255
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        tick
);
  localparam logic [1:0] ADR_TIME = 2'd0;
  localparam logic [1:0] ADR_DATE = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_DIV  = 2'd3;
  localparam int         A_LSB    = 16;

  logic           init_req, init_s1, initf;
  logic           rsf, tick_d;
  logic [1:0]     sync_pipe;
  logic [A_W-1:0] a_div;
  logic [S_W-1:0] s_div;
  logic [31:0]    live_time, live_date, shd_time, shd_date;
  logic           wr_stat, rsf_clr, copy, inits;
  logic           ld_time, ld_date, ld_div;

  assign wr_stat = wr_en && (addr == ADR_STAT);
  assign rsf_clr = wr_stat && !wdata[2];
  assign ld_time = wr_en && (addr == ADR_TIME) && initf;
  assign ld_date = wr_en && (addr == ADR_DATE) && initf;
  assign ld_div  = wr_en && (addr == ADR_DIV)  && initf;
  assign copy    = initf || tick_d || sync_pipe[1];
  assign inits   = live_date[23:16] != 8'h00;

  // init request and its two-flop acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      init_req <= 1'b0;
      init_s1  <= 1'b0;
      initf    <= 1'b0;
    end else begin
      if (wr_stat) init_req <= wdata[0];
      init_s1 <= init_req;
      initf   <= init_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_div <= A_W'(A_RESET);
      s_div <= S_W'(S_RESET);
    end else if (ld_div) begin
      a_div <= wdata[A_LSB +: A_W];
      s_div <= wdata[S_W-1:0];
    end
  end

  rtc_prescaler #(.A_W(A_W), .S_W(S_W)) u_presc (
    .clk(clk), .rst(rst), .hold(initf),
    .a_div(a_div), .s_div(s_div), .tick(tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .hold(initf), .step(tick && !initf),
    .load_time(ld_time), .load_date(ld_date), .wr_word(wdata),
    .time_word(live_time), .date_word(live_date)
  );

  // shadow copies and resync flag
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d    <= 1'b0;
      sync_pipe <= 2'b00;
      rsf       <= 1'b1;
      shd_time  <= 32'h0000_0000;
      shd_date  <= 32'h0000_2101;
    end else begin
      tick_d    <= tick;
      sync_pipe <= {sync_pipe[0], rsf_clr};
      if (rsf_clr)   rsf <= 1'b0;
      else if (copy) rsf <= 1'b1;
      if (copy) begin
        shd_time <= live_time;
        shd_date <= live_date;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 32'h0;
    end else if (rd_en) begin
      case (addr)
        ADR_TIME: rdata <= shd_time;
        ADR_DATE: rdata <= shd_date;
        ADR_STAT: rdata <= {28'b0, inits, rsf, initf, init_req};
        default:  rdata <= {9'b0, 7'(a_div), 1'b0, 15'(s_div)};
      endcase
    end
  end

  AST_INITF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(initf) |-> $past(init_req, 2)); // R2

  AST_INITF_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(initf) |-> !$past(init_req, 2)); // R2

  AST_RSF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    rsf_clr |=> !rsf); // R9

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_TIME && !initf && !tick) |=> $stable(live_time)); // R3

endmodule

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tick;
  int          n_checks = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  bcd_rtc dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick)
  );

  function automatic logic [31:0] mkd(input logic [7:0] y, input logic [2:0] w,
                                      input logic [7:0] m, input logic [7:0] d);
    return {8'h0, y, w, m[4:0], 2'b00, d[5:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_init();
    logic [31:0] s;
    wr(2'd2, 32'h5);
    s = 0;
    for (int i = 0; i < 20 && !s[1]; i++) rd(2'd2, s);
  endtask

  task automatic exit_init();
    wr(2'd2, 32'h4);
    idle(3);
  endtask

  task automatic wait_tick(input string req);
    int k = 0;
    while (!tick && k < 2000) begin @(negedge clk); k++; end
    if (!tick) chk({req, " tick seen"}, 32'h0, 32'h1);
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d);
    enter_init();
    wr(2'd0, t);
    wr(2'd1, d);
    exit_init();
  endtask

  // one second from a loaded value, then compare
  task automatic t_step(input string req, input logic [31:0] t0, input logic [31:0] d0,
                        input logic [31:0] t1, input logic [31:0] d1);
    logic [31:0] v;
    load(t0, d0);
    wait_tick(req);
    idle(3);
    rd(2'd0, v); chk({req, " time"}, v, t1);
    rd(2'd1, v); chk({req, " date"}, v, d1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 time", v, 32'h0);
    rd(2'd1, v); chk("R1 date", v, 32'h0000_2101);
    rd(2'd2, v); chk("R1 status", v, 32'h4);
    rd(2'd3, v); chk("R1 divider", v, 32'h007F_00FF);
  endtask

  task automatic t_rsf();
    logic [31:0] a, b, c;
    wr(2'd2, 32'h4);
    rd(2'd2, a); chk("R9 write one keeps flag", {31'b0, a[2]}, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, a); rd(2'd2, b); rd(2'd2, c);
    chk("R9 first read after clear", {31'b0, a[2]}, 32'h0);
    chk("R9 second read after clear", {31'b0, b[2]}, 32'h0);
    chk("R9 third read after clear", {31'b0, c[2]}, 32'h1);
  endtask

  task automatic t_ignore_and_handshake();
    logic [31:0] a, b, c;
    wr(2'd0, 32'h0012_3456);
    wr(2'd1, mkd(8'h55, 3'd3, 8'h07, 8'h15));
    wr(2'd3, 32'h0001_0002);
    wr(2'd2, 32'h5);
    rd(2'd2, a); rd(2'd2, b); rd(2'd2, c);
    chk("R2 ack low one read after request", {31'b0, b[1]}, 32'h0);
    chk("R2 ack high two reads after request", {31'b0, c[1]}, 32'h1);
    idle(2);
    rd(2'd0, a); chk("R3 time write ignored", a, 32'h0);
    rd(2'd1, a); chk("R3 date write ignored", a, 32'h0000_2101);
    rd(2'd3, a); chk("R3 divider write ignored", a, 32'h007F_00FF);
    wr(2'd2, 32'h4);
    rd(2'd2, a); rd(2'd2, b); rd(2'd2, c);
    chk("R2 ack still high after release", {31'b0, b[1]}, 32'h1);
    chk("R2 ack low after release", {31'b0, c[1]}, 32'h0);
  endtask

  task automatic t_freeze_and_wrap();
    logic [31:0] v;
    int k, seen;
    enter_init();
    wr(2'd3, 32'h0001_0002);
    wr(2'd0, 32'h0023_5959);
    wr(2'd1, mkd(8'h99, 3'd7, 8'h12, 8'h31));
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tick) seen++; end
    chk("R4 no tick in init mode", seen, 0);
    rd(2'd0, v); chk("R11 time frozen in init", v, 32'h0023_5959);
    rd(2'd3, v); chk("R4 divider loaded", v, 32'h0001_0002);
    rd(2'd2, v); chk("R10 initialized flag with year 99", {31'b0, v[3]}, 32'h1);
    exit_init();
    wait_tick("R12");
    idle(3);
    rd(2'd0, v); chk("R5 R11 midnight rollover", v, 32'h0);
    rd(2'd1, v); chk("R6 R8 R12 year wrap date", v, mkd(8'h00, 3'd1, 8'h01, 8'h01));
    rd(2'd2, v); chk("R10 flag clear with year 00", {31'b0, v[3]}, 32'h0);
    wait_tick("R4");
    k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 100);
    chk("R4 tick period", k, 6);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 32'h0;
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_rsf();
    t_ignore_and_handshake();
    t_freeze_and_wrap();
    t_step("R5 digit carry", 32'h0009_0959, mkd(8'h23, 3'd2, 8'h05, 8'h10),
           32'h0009_1000, mkd(8'h23, 3'd2, 8'h05, 8'h10));
    t_step("R5 hour carry", 32'h0010_5959, mkd(8'h23, 3'd2, 8'h05, 8'h10),
           32'h0011_0000, mkd(8'h23, 3'd2, 8'h05, 8'h10));
    t_step("R7 leap 24", 32'h0023_5959, mkd(8'h24, 3'd3, 8'h02, 8'h28),
           32'h0, mkd(8'h24, 3'd4, 8'h02, 8'h29));
    t_step("R7 common 23", 32'h0023_5959, mkd(8'h23, 3'd2, 8'h02, 8'h28),
           32'h0, mkd(8'h23, 3'd3, 8'h03, 8'h01));
    t_step("R7 leap 12 end", 32'h0023_5959, mkd(8'h12, 3'd5, 8'h02, 8'h29),
           32'h0, mkd(8'h12, 3'd6, 8'h03, 8'h01));
    t_step("R7 common 10", 32'h0023_5959, mkd(8'h10, 3'd1, 8'h02, 8'h28),
           32'h0, mkd(8'h10, 3'd2, 8'h03, 8'h01));
    t_step("R6 R8 April end", 32'h0023_5959, mkd(8'h23, 3'd7, 8'h04, 8'h30),
           32'h0, mkd(8'h23, 3'd1, 8'h05, 8'h01));
    t_step("R6 January 30", 32'h0023_5959, mkd(8'h23, 3'd1, 8'h01, 8'h30),
           32'h0, mkd(8'h23, 3'd2, 8'h01, 8'h31));
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule